// File: doc/BRIEF.md
# Alarm Comparator Bank

The block holds three alarm comparators that watch free-running tick counts supplied from outside. Each comparator compares against one of two 64-bit counter units, picked by its own select bit. In one-shot mode it fires once, when the selected count reaches a 64-bit target. In periodic mode it fires every N ticks, where N is a 26-bit interval. When a comparator fires it sets a raw interrupt flag. An enable bit gates that flag onto the interrupt output, and a write-one clear pulse removes it.

Target and interval values are not written straight into the compare logic. Software first writes them, 32 bits at a time, into per-comparator staging registers through a small configuration port. A commit strobe then copies the staged values into the active registers of the selected comparator. Mode, counter selection, work enable, interrupt enable and interrupt clear are plain per-comparator level or pulse inputs. The block has no streaming data path, so it has no valid/ready interface. The configuration port takes one operation per cycle and never stalls.

Top module: `alarm_bank`

## Requirements
- R1: After reset every raw flag and every interrupt output is 0, and no comparator is armed: in one-shot mode nothing fires until a commit has been made for that comparator.
- R2: `cfg_op_i` selects the staging write for the comparator addressed by `cfg_sel_i`: 0 does nothing, 1 writes `cfg_data_i` to target bits 63:32, 2 writes it to target bits 31:0, and 3 writes the interval. Staged values have no effect on comparison until a commit to that same comparator. A commit to another comparator leaves this one unchanged.
- R3: In one-shot mode (mode bit 0), a committed and enabled comparator sets its raw flag at the clock edge that ends the first cycle in which the selected count is greater than or equal to the active target. This includes targets that cross the 32-bit half boundary. It fires only once per commit.
- R4: When the mode bit goes from 0 to 1, the next fire point becomes the current count plus the active interval, and nothing fires in that cycle. Each fire in periodic mode then moves the fire point forward by the interval, so fires occur at count offsets N, 2N, 3N. Toggling the mode again restarts the interval from the count at that time.
- R5: Unit-select bit 0 compares against `cnt0_i`, and 1 compares against `cnt1_i`. The count that is not selected has no effect.
- R6: A comparator whose work-enable bit is 0 never sets its raw flag. A one-shot comparator that stays armed fires on the first enabled cycle in which its condition holds.
- R7: `irq_o[i]` equals the AND of the raw flag and `int_ena_i[i]`.
- R8: A pulse on `int_clr_i[i]` clears raw flag i at the next edge. If a fire and a clear happen in the same cycle, the flag is left set.
- R9: An interval write keeps only `cfg_data_i[25:0]`. Bits 31:26 are ignored.
- R10: A commit copies the staged values as they stood before that cycle, so a staging write made in the same cycle as the commit is kept for a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt0_i | input | 64 | Counter unit 0 value |
| cnt1_i | input | 64 | Counter unit 1 value |
| cfg_sel_i | input | 2 | Comparator addressed by staging writes and commit |
| cfg_op_i | input | 2 | Staging operation: 0 none, 1 target high, 2 target low, 3 interval |
| cfg_data_i | input | 32 | Staging write data |
| commit_i | input | 1 | Copies staged values of the addressed comparator to its active registers |
| work_en_i | input | 3 | Per-comparator work enable |
| unit_sel_i | input | 3 | Per-comparator counter unit select (0: unit 0, 1: unit 1) |
| mode_i | input | 3 | Per-comparator mode (0: one-shot, 1: periodic) |
| int_ena_i | input | 3 | Per-comparator interrupt enable |
| int_clr_i | input | 3 | Per-comparator write-one clear of the raw flag |
| int_raw_o | output | 3 | Raw interrupt flags |
| irq_o | output | 3 | Gated interrupt outputs |

## Verification
Two cases are hard to reach from the ports. One is a fire and a clear landing in the same cycle. The other is a periodic restart that happens between two fire points. The bench supplies the counter values itself. It freezes the count while it stages and commits a value, then steps the count one tick per cycle, so the fire offsets can be computed in advance. In every periodic run the clear input is held high, so the raw flag after each edge shows exactly whether a fire happened in that cycle. The restart case toggles the mode in the middle of an interval and checks that the next fire follows the new phase, not the old one.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  typedef enum logic {
    CMP_ONESHOT  = 1'b0,
    CMP_PERIODIC = 1'b1
  } cmp_mode_e;

  typedef enum logic [1:0] {
    SH_NOP    = 2'd0,
    SH_TGT_HI = 2'd1,
    SH_TGT_LO = 2'd2,
    SH_PERIOD = 2'd3
  } shadow_op_e;

endpackage

// File: rtl/alarm_shadow.sv
module alarm_shadow
  import alarm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PER_W  = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_i,
  input  shadow_op_e          op_i,
  input  logic [WORD_W-1:0]   data_i,
  input  logic                load_i,
  output logic [2*WORD_W-1:0] tgt_act_o,
  output logic [PER_W-1:0]    per_act_o
);

  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] tgt_stage;
  logic [PER_W-1:0] per_stage;

  // staging registers, one 32-bit half or the interval per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_stage <= '0;
      per_stage <= '0;
    end else if (sel_i) begin
      case (op_i)
        SH_TGT_HI: tgt_stage[CNT_W-1:WORD_W] <= data_i;
        SH_TGT_LO: tgt_stage[WORD_W-1:0]     <= data_i;
        SH_PERIOD: per_stage                 <= data_i[PER_W-1:0];
        default:   ;
      endcase
    end
  end

  // active registers see the staged state from before this cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_act_o <= '0;
      per_act_o <= '0;
    end else if (sel_i && load_i) begin
      tgt_act_o <= tgt_stage;
      per_act_o <= per_stage;
    end
  end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int PER_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt0_i,
  input  logic [CNT_W-1:0] cnt1_i,
  input  logic             unit_sel_i,
  input  cmp_mode_e        mode_i,
  input  logic             work_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tgt_i,
  input  logic [PER_W-1:0] per_i,
  output logic             fire_o
);

  logic [CNT_W-1:0] cnt_sel;
  logic [CNT_W-1:0] per_ext;
  logic [CNT_W-1:0] next_fire;
  logic             armed;
  logic             was_periodic;
  logic             period_start;
  logic             hit_tgt;
  logic             hit_per;

  assign cnt_sel      = unit_sel_i ? cnt1_i : cnt0_i;
  assign per_ext      = {{(CNT_W-PER_W){1'b0}}, per_i};
  assign period_start = (mode_i == CMP_PERIODIC) && !was_periodic;

  always_comb begin
    hit_tgt = 1'b0;
    hit_per = 1'b0;
    if (mode_i == CMP_ONESHOT) begin
      hit_tgt = armed && (cnt_sel >= tgt_i);
    end else if (was_periodic) begin
      hit_per = cnt_sel >= next_fire;
    end
  end

  assign fire_o = work_en_i && (hit_tgt || hit_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      was_periodic <= 1'b0;
      next_fire    <= '0;
    end else begin
      was_periodic <= (mode_i == CMP_PERIODIC);
      if (load_i) begin
        armed <= 1'b1;
      end else if (fire_o && (mode_i == CMP_ONESHOT)) begin
        armed <= 1'b0;
      end
      if (period_start) begin
        next_fire <= cnt_sel + per_ext;
      end else if (fire_o && (mode_i == CMP_PERIODIC)) begin
        next_fire <= next_fire + per_ext;
      end
    end
  end

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clr_i,
  input  logic ena_i,
  output logic raw_o,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= 1'b0;
    end else if (fire_i) begin
      raw_o <= 1'b1;
    end else if (clr_i) begin
      raw_o <= 1'b0;
    end
  end

  assign irq_o = raw_o && ena_i;

endmodule

// File: rtl/alarm_bank.sv
module alarm_bank
  import alarm_pkg::*;
#(
  parameter int N_ALARM = 3,
  parameter int WORD_W  = 32,
  parameter int PER_W   = 26
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*WORD_W-1:0]         cnt0_i,
  input  logic [2*WORD_W-1:0]         cnt1_i,
  input  logic [$clog2(N_ALARM)-1:0]  cfg_sel_i,
  input  logic [1:0]                  cfg_op_i,
  input  logic [WORD_W-1:0]           cfg_data_i,
  input  logic                        commit_i,
  input  logic [N_ALARM-1:0]          work_en_i,
  input  logic [N_ALARM-1:0]          unit_sel_i,
  input  logic [N_ALARM-1:0]          mode_i,
  input  logic [N_ALARM-1:0]          int_ena_i,
  input  logic [N_ALARM-1:0]          int_clr_i,
  output logic [N_ALARM-1:0]          int_raw_o,
  output logic [N_ALARM-1:0]          irq_o
);

  localparam int CNT_W = 2 * WORD_W;
  localparam int IDX_W = $clog2(N_ALARM);

  shadow_op_e op;
  assign op = shadow_op_e'(cfg_op_i);

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
    logic             hit_sel;
    logic [CNT_W-1:0] tgt_act;
    logic [PER_W-1:0] per_act;
    logic             fire;

    assign hit_sel = (cfg_sel_i == IDX_W'(i));

    alarm_shadow #(
      .WORD_W (WORD_W),
      .PER_W  (PER_W)
    ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (hit_sel),
      .op_i      (op),
      .data_i    (cfg_data_i),
      .load_i    (commit_i),
      .tgt_act_o (tgt_act),
      .per_act_o (per_act)
    );

    alarm_cmp #(
      .CNT_W (CNT_W),
      .PER_W (PER_W)
    ) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt0_i     (cnt0_i),
      .cnt1_i     (cnt1_i),
      .unit_sel_i (unit_sel_i[i]),
      .mode_i     (cmp_mode_e'(mode_i[i])),
      .work_en_i  (work_en_i[i]),
      .load_i     (commit_i && hit_sel),
      .tgt_i      (tgt_act),
      .per_i      (per_act),
      .fire_o     (fire)
    );

    alarm_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire),
      .clr_i  (int_clr_i[i]),
      .ena_i  (int_ena_i[i]),
      .raw_o  (int_raw_o[i]),
      .irq_o  (irq_o[i])
    );
  end

endmodule

// File: rtl/alarm_bank_chk.sv
module alarm_bank_chk #(
  parameter int N_ALARM = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_ALARM-1:0] work_en_i,
  input logic [N_ALARM-1:0] int_ena_i,
  input logic [N_ALARM-1:0] int_clr_i,
  input logic [N_ALARM-1:0] int_raw_o,
  input logic [N_ALARM-1:0] irq_o
);

  for (genvar i = 0; i < N_ALARM; i++) begin : g_chk
    p_rise_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_raw_o[i]) |-> $past(work_en_i[i]))
      else $error("R6 raw flag rose while comparator disabled");

    p_hold_until_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_raw_o[i] && !int_clr_i[i]) |=> int_raw_o[i])
      else $error("R8 raw flag dropped without clear");

    p_clr_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr_i[i] && !work_en_i[i]) |=> !int_raw_o[i])
      else $error("R8 clear did not take effect");

    p_gate_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ena_i[i] |-> !irq_o[i])
      else $error("R7 interrupt output while disabled");
  end

endmodule

bind alarm_bank alarm_bank_chk #(.N_ALARM(N_ALARM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .work_en_i (work_en_i),
  .int_ena_i (int_ena_i),
  .int_clr_i (int_clr_i),
  .int_raw_o (int_raw_o),
  .irq_o     (irq_o)
);

// File: tb/alarm_bank_bench.sv
module alarm_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] C = 64'h0000_0001_FFFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt0 = '0;
  logic [63:0] cnt1 = '0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_op = '0;
  logic [31:0] cfg_data = '0;
  logic        commit = 1'b0;
  logic [2:0]  work_en = '0;
  logic [2:0]  unit_sel = '0;
  logic [2:0]  mode = '0;
  logic [2:0]  int_ena = '0;
  logic [2:0]  int_clr = '0;
  logic [2:0]  int_raw;
  logic [2:0]  irq;
  logic [63:0] tmp;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alarm_bank u_alarm_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt0_i     (cnt0),
    .cnt1_i     (cnt1),
    .cfg_sel_i  (cfg_sel),
    .cfg_op_i   (cfg_op),
    .cfg_data_i (cfg_data),
    .commit_i   (commit),
    .work_en_i  (work_en),
    .unit_sel_i (unit_sel),
    .mode_i     (mode),
    .int_ena_i  (int_ena),
    .int_clr_i  (int_clr),
    .int_raw_o  (int_raw),
    .irq_o      (irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [1:0] op, input logic [31:0] d);
    cfg_sel = 2'(a); cfg_op = op; cfg_data = d;
    tick();
    cfg_op = 2'd0;
  endtask

  task automatic do_commit(input int a);
    cfg_sel = 2'(a); commit = 1'b1;
    tick();
    commit = 1'b0;
  endtask

  task automatic load_target(input int a, input logic [63:0] t);
    wr(a, 2'd1, t[63:32]);
    wr(a, 2'd2, t[31:0]);
    do_commit(a);
  endtask

  task automatic clr_all();
    int_clr = 3'b111;
    tick();
    int_clr = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset state, nothing armed before a commit
    repeat (3) tick();
    chk(int_raw == 3'b000, "R1 raw after reset", 64'(int_raw), 0);
    chk(irq == 3'b000, "R1 irq after reset", 64'(irq), 0);
    rst_n = 1'b1;
    cnt0 = '1; work_en = 3'b111; int_ena = 3'b111;
    repeat (3) tick();
    chk(int_raw == 3'b000, "R1 unarmed one-shot stays quiet", 64'(int_raw), 0);
    chk(irq == 3'b000, "R1 irq quiet", 64'(irq), 0);
    work_en = '0; int_ena = '0;

    // R3/R7/R8/R5: one-shot sweep over target offsets, crossing the half boundary
    for (int a = 0; a < 3; a++) begin
      for (int d = 0; d < 6; d++) begin
        work_en = '0; mode = '0; unit_sel = '0; int_ena = '0;
        cnt0 = C; cnt1 = '1;   // unit 1 above every target, must be ignored (R5)
        clr_all();
        load_target(a, C + 64'(d));
        int_ena[a] = d[0];
        work_en[a] = 1'b1;
        for (int k = 0; k <= d + 1; k++) begin
          cnt0 = C + 64'(k);
          tick();
          chk(int_raw[a] == (k >= d), "R3 one-shot fire point", 64'(int_raw[a]), 64'(k >= d));
          chk(irq[a] == ((k >= d) && d[0]), "R7 irq gating", 64'(irq[a]),
              64'((k >= d) && d[0]));
        end
        int_clr[a] = 1'b1; cnt0 = C + 64'(d + 2);
        tick();
        int_clr[a] = 1'b0;
        chk(int_raw[a] == 1'b0, "R8 clear pulse", 64'(int_raw[a]), 0);
        for (int k = d + 3; k <= d + 4; k++) begin
          cnt0 = C + 64'(k);
          tick();
          chk(int_raw[a] == 1'b0, "R3 fires once per commit", 64'(int_raw[a]), 0);
        end
      end
    end
    work_en = '0; int_ena = '0;

    // R5: unit 1 selected, unit 0 above target must not matter
    for (int a = 0; a < 3; a++) begin
      work_en = '0; mode = '0; unit_sel = '0;
      cnt0 = C; cnt1 = C;
      clr_all();
      load_target(a, C + 64'd10);
      unit_sel[a] = 1'b1; cnt0 = C + 64'd100; work_en[a] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        cnt1 = C + 64'(8 + k);
        tick();
        chk(int_raw[a] == (k >= 2), "R5 unit 1 compare", 64'(int_raw[a]), 64'(k >= 2));
      end
    end
    work_en = '0; unit_sel = '0;

    // R6: disabled comparator never fires; armed one fires once enabled
    cnt0 = C;
    clr_all();
    load_target(2, C + 64'd1);
    for (int k = 0; k < 5; k++) begin
      cnt0 = C + 64'(k);
      tick();
      chk(int_raw[2] == 1'b0, "R6 disabled quiet", 64'(int_raw[2]), 0);
    end
    work_en[2] = 1'b1;
    tick();
    chk(int_raw[2] == 1'b1, "R6 late enable fires", 64'(int_raw[2]), 1);
    work_en = '0;

    // R4/R8/R9: periodic sweep, clear held high so raw equals this cycle's fire
    for (int a = 0; a < 3; a++) begin
      for (int p = 1; p <= 5; p++) begin
        work_en = '0; mode = '0; cnt0 = C;
        clr_all();
        wr(a, 2'd3, {6'b110101, 26'(p)});   // R9 upper bits ignored
        do_commit(a);
        mode[a] = 1'b1; work_en[a] = 1'b1; int_clr[a] = 1'b1;
        tick();
        chk(int_raw[a] == 1'b0, "R4 no fire on restart", 64'(int_raw[a]), 0);
        for (int k = 1; k <= 3 * p; k++) begin
          cnt0 = C + 64'(k);
          tick();
          chk(int_raw[a] == ((k % p) == 0), "R4/R8/R9 periodic fire, set beats clear",
              64'(int_raw[a]), 64'((k % p) == 0));
        end
        int_clr[a] = 1'b0; work_en[a] = 1'b0; mode[a] = 1'b0;
        tick();
      end
    end

    // R4: restart in the middle of an interval moves the phase
    work_en = '0; mode = '0; cnt0 = C;
    clr_all();
    wr(0, 2'd3, 32'd4);
    do_commit(0);
    mode[0] = 1'b1; work_en[0] = 1'b1; int_clr[0] = 1'b1;
    tick();
    for (int k = 1; k <= 5; k++) begin
      cnt0 = C + 64'(k);
      tick();
      chk(int_raw[0] == (k == 4), "R4 first phase", 64'(int_raw[0]), 64'(k == 4));
    end
    work_en[0] = 1'b0; mode[0] = 1'b0; cnt0 = C + 64'd6;
    tick();
    work_en[0] = 1'b1; mode[0] = 1'b1; cnt0 = C + 64'd7;
    tick();
    chk(int_raw[0] == 1'b0, "R4 restart cycle", 64'(int_raw[0]), 0);
    for (int k = 8; k <= 12; k++) begin
      cnt0 = C + 64'(k);
      tick();
      chk(int_raw[0] == (k == 11), "R4 restarted phase", 64'(int_raw[0]), 64'(k == 11));
    end
    int_clr = '0; work_en = '0; mode = '0;

    // R2: staged value is inert until its own commit
    cnt0 = C;
    clr_all();
    load_target(1, C + 64'd3);
    wr(1, 2'd1, C[63:32]);
    wr(1, 2'd2, C[31:0]);
    do_commit(2);
    work_en[1] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cnt0 = C + 64'(k);
      tick();
      chk(int_raw[1] == (k >= 3), "R2 staged target inert", 64'(int_raw[1]), 64'(k >= 3));
    end

    // R10: write and commit in one cycle commits the earlier staged value
    work_en = '0; cnt0 = C;
    clr_all();
    tmp = C + 64'd50;
    cfg_sel = 2'd1; cfg_op = 2'd2; cfg_data = tmp[31:0]; commit = 1'b1;
    tick();
    cfg_op = 2'd0; commit = 1'b0;
    work_en[1] = 1'b1;
    tick();
    chk(int_raw[1] == 1'b1, "R10 commit takes prior staging", 64'(int_raw[1]), 1);
    work_en = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule